// File: doc/BRIEF.md
# Burst-Locked DMA Bus Arbiter

This block decides which of four DMA channels owns a shared memory bus. Each channel raises its request line when it is ready to move a block of words and pulses its done line in the cycle its block finishes. The arbiter answers with a one-hot grant. Once a channel holds the grant, the arbiter keeps it there until that channel's block is finished, so a block is never split by another channel.

Because a channel only requests again after its inter-block interval has elapsed, a second channel that is waiting can take the bus between two blocks of the first. A single policy input selects the arbitration rule. In fixed priority the lowest-numbered requester wins. In round robin the search starts just after the channel whose block completed last. The policy input is read only when a new decision is taken, so switching it never disturbs a block that is already under way.

Top module: `dma_burst_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no grant bit is set. The round-robin search then begins at channel 0.
- R2: At most one bit of the grant output is set in any cycle.
- R3: A channel is granted only if its request bit was high in the cycle the decision was taken. Grant bit i belongs to channel i and to request and done bit i.
- R4: While a channel holds the grant and its own done bit is low, the grant stays unchanged. Done pulses from other channels and changes on any request line have no effect.
- R5: When no grant is held and at least one request is high, a grant appears in the following cycle.
- R6: When the holder's done bit is high, the next grant goes to the arbitration winner among the other requesting channels. The finishing holder is excluded. If none of the other channels is requesting, the grant drops to all zeros.
- R7: With the policy input at 0 (fixed priority), the requesting channel with the lowest index wins.
- R8: With the policy input at 1 (round robin), the search starts at the channel one above the last channel whose block completed, modulo four. The reference point moves only when a block completes.
- R9: The policy input is sampled only in a decision cycle, meaning a cycle that is idle or has the holder's done bit high. Toggling it during a block leaves that block's grant untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode_i | input | 1 | Policy select: 0 fixed priority, 1 round robin |
| req_i | input | NUM_CH | Per-channel request, bit i is channel i |
| done_i | input | NUM_CH | Per-channel block-complete pulse |
| grant_o | output | NUM_CH | One-hot bus grant, bit i is channel i |

## Verification
The bench builds the arbiter with its default NUM_CH of 4, the channel count the bus actually has. With four channels, every rotation of the round-robin reference point can be reached, including wrap-around from channel 3 to channel 0. Every request subset and stray done pattern can also be reached through directed and random stimulus. The bench's behavioural model predicts the grant and is compared against the grant on every clock. Policy toggles fall both inside blocks and on decision cycles.

// File: rtl/dab_pkg.sv
package dab_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dab_fixed_pick.sv
module dab_fixed_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] pick_o
);
  logic found;

  always_comb begin
    pick_o = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && req_i[i]) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  // lowest index wins: the pick is one-hot and lies inside the request set
  always_comb begin
    AST_FIX_PICK_ONEHOT: assert ($onehot0(pick_o)); // R7
    AST_FIX_PICK_IN_REQ: assert ((pick_o & ~req_i) == '0); // R3
  end
endmodule

// File: rtl/dab_rr_pick.sv
module dab_rr_pick #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [IDX_W-1:0]  base_i,
  output logic [NUM_CH-1:0] pick_o
);
  logic found;
  int   idx;

  always_comb begin
    pick_o = '0;
    found  = 1'b0;
    idx    = 0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = (int'(base_i) + k) % NUM_CH;
      if (!found && req_i[idx]) begin
        pick_o[idx] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  // any request present must produce exactly one pick
  always_comb begin
    AST_RR_PICK_ONEHOT: assert ($onehot0(pick_o)); // R8
    AST_RR_PICK_LIVE:   assert ((req_i == '0) || (pick_o != '0)); // R5
  end
endmodule

// File: rtl/dab_state.sv
module dab_state #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decide_i,
  input  logic [NUM_CH-1:0] next_grant_i,
  input  logic              holder_done_i,
  input  logic [IDX_W-1:0]  holder_idx_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic [IDX_W-1:0]  last_o
);
  localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(NUM_CH - 1);

  logic [NUM_CH-1:0] grant_d;
  logic [IDX_W-1:0]  last_d;

  // next-state: grant moves only in a decision cycle, pointer only on completion
  always_comb begin
    grant_d = grant_o;
    last_d  = last_o;
    if (decide_i)      grant_d = next_grant_i;
    if (holder_done_i) last_d  = holder_idx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o <= '0;
      last_o  <= LAST_RST;
    end else begin
      grant_o <= grant_d;
      last_o  <= last_d;
    end
  end

  AST_PTR_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !holder_done_i |=> $stable(last_o)); // R8
endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rr_mode_i,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] grant_o
);
  import dab_pkg::*;

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] grant_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  holder_idx;
  logic [IDX_W-1:0]  search_base;
  logic [NUM_CH-1:0] cand;
  logic [NUM_CH-1:0] pick_fixed;
  logic [NUM_CH-1:0] pick_rr;
  logic [NUM_CH-1:0] next_grant;
  logic              bus_busy;
  logic              holder_done;
  logic              decide;
  arb_mode_e         mode;

  always_comb begin
    holder_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grant_q[i]) holder_idx = IDX_W'(i);
    end
  end

  assign bus_busy    = |grant_q;
  assign holder_done = |(done_i & grant_q);
  assign decide      = !bus_busy || holder_done;
  // the finishing holder never competes for the bus it is giving up
  assign cand        = req_i & ~grant_q;
  assign search_base = bus_busy ? holder_idx : last_q;
  assign mode        = arb_mode_e'(rr_mode_i);

  dab_fixed_pick #(.NUM_CH(NUM_CH)) u_fixed (
    .req_i  (cand),
    .pick_o (pick_fixed)
  );

  dab_rr_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_rr (
    .req_i  (cand),
    .base_i (search_base),
    .pick_o (pick_rr)
  );

  always_comb begin
    next_grant = pick_fixed;
    if (mode == ARB_ROUND) next_grant = pick_rr;
  end

  dab_state #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .decide_i      (decide),
    .next_grant_i  (next_grant),
    .holder_done_i (holder_done),
    .holder_idx_i  (holder_idx),
    .grant_o       (grant_q),
    .last_o        (last_q)
  );

  assign grant_o = grant_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R2
  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !$stable(grant_o)) |-> ((grant_o & $past(req_i)) != '0)); // R3
  AST_BURST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && (done_i & grant_o) == '0) |=> $stable(grant_o)); // R4
  AST_IDLE_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0 && req_i != '0) |=> (grant_o != '0)); // R5
  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0 && req_i[0] && !rr_mode_i) |=> grant_o[0]); // R7
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_i & grant_o) != '0) |=> (grant_o != $past(grant_o))); // R6
endmodule

// File: tb/dma_burst_arbiter_tb.sv
module dma_burst_arbiter_tb;
  localparam int NUM_CH   = 4;
  localparam int CLK_PER  = 10;
  localparam int WATCHDOG = 20000;

  logic              clk;
  logic              rst_n;
  logic              rr_mode;
  logic [NUM_CH-1:0] req;
  logic [NUM_CH-1:0] done;
  logic [NUM_CH-1:0] grant;

  int    checks;
  int    errors;
  int    cycles;
  string tag;

  // behavioural reference state
  int hold;
  int last_done;

  dma_burst_arbiter #(.NUM_CH(NUM_CH)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rr_mode_i (rr_mode),
    .req_i     (req),
    .done_i    (done),
    .grant_o   (grant)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      = -1;
      last_done = NUM_CH - 1;
    end else if (hold < 0 || done[hold]) begin
      int winner;
      logic [NUM_CH-1:0] want;
      want = req;
      if (hold >= 0) begin
        want[hold] = 1'b0;
        last_done  = hold;
      end
      winner = -1;
      if (rr_mode) begin
        for (int k = 1; k <= NUM_CH; k++) begin
          if (winner < 0 && want[(last_done + k) % NUM_CH]) winner = (last_done + k) % NUM_CH;
        end
      end else begin
        for (int i = NUM_CH - 1; i >= 0; i--) begin
          if (want[i]) winner = i;
        end
      end
      hold = winner;
    end
  end

  function automatic logic [NUM_CH-1:0] expected();
    return (hold < 0) ? '0 : (NUM_CH'(1) << hold);
  endfunction

  task automatic check_now();
    checks++;
    if (grant !== expected()) begin
      errors++;
      $display("FAIL %s: grant actual=%b expected=%b at cycle %0d", tag, grant, expected(), cycles);
    end
  endtask

  // one clock: check at the falling edge, then drive the next inputs
  task automatic step(input logic [NUM_CH-1:0] r, input logic [NUM_CH-1:0] d, input logic m);
    @(negedge clk);
    check_now();
    req     = r;
    done    = d;
    rr_mode = m;
  endtask

  task automatic check_exact(input logic [NUM_CH-1:0] want);
    checks++;
    if (grant !== want) begin
      errors++;
      $display("FAIL %s: grant actual=%b expected=%b", tag, grant, want);
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; errors = 0;
    req = '0; done = '0; rr_mode = 1'b0;
    rst_n = 1'b0;
    tag = "R1";
    repeat (3) @(negedge clk);
    check_exact('0);
    rst_n = 1'b1;
    step('0, '0, 1'b0);
    check_exact('0); // R1 first cycle out of reset

    tag = "R7";
    step(4'b1010, '0, 1'b0);
    step(4'b1010, '0, 1'b0);
    check_exact(4'b0010); // R7 lowest index among 1 and 3

    tag = "R4";
    step(4'b1111, 4'b1101, 1'b0);
    step(4'b0000, 4'b1000, 1'b0);
    check_exact(4'b0010); // R4 held against foreign done and request changes

    tag = "R6";
    step(4'b1100, 4'b0010, 1'b0);
    step(4'b1100, '0, 1'b0);
    check_exact(4'b0100); // R6 handoff to next winner
    step('0, 4'b0100, 1'b0);
    step('0, '0, 1'b0);
    check_exact('0); // R6 release to idle

    tag = "R5";
    step(4'b1000, '0, 1'b0);
    step('0, '0, 1'b0);
    check_exact(4'b1000); // R5 idle request served next cycle
    step('0, 4'b1000, 1'b1);

    tag = "R8";
    step(4'b1011, '0, 1'b1);
    step(4'b1011, '0, 1'b1);
    check_exact(4'b0001); // R8 wrap after channel 3 completed
    step(4'b1011, 4'b0001, 1'b1);
    step(4'b1011, '0, 1'b1);
    check_exact(4'b0010); // R8 next after channel 0

    tag = "R9";
    step(4'b1111, '0, 1'b0);
    step(4'b1111, '0, 1'b1);
    check_exact(4'b0010); // R9 mode toggles mid-block
    step(4'b1101, 4'b0010, 1'b0);
    step(4'b1101, '0, 1'b0);
    check_exact(4'b0001); // R9 fixed mode sampled at decision

    tag = "R2 R3 random";
    for (int n = 0; n < 3000; n++) begin
      logic [NUM_CH-1:0] r;
      logic [NUM_CH-1:0] d;
      r = NUM_CH'($urandom);
      d = ($urandom % 3 == 0) ? NUM_CH'($urandom) : '0;
      step(r, d, (n / 200) % 2 == 1 ? 1'b1 : ($urandom % 7 == 0));
    end
    step('0, '0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule